// File: doc/BRIEF.md
# Beam-Spot Offset Correction Unit

This unit sits in a track stream and corrects the impact parameter (d0) of each track for a beam spot that is displaced from the detector origin. Every track arrives as seven words on consecutive valid beats. The first word carries the track's azimuth index and its longitudinal segment. The second word carries the signed d0. Two trigonometric values for that azimuth and segment are fetched from an external banked table memory. The sine and cosine lanes are read in parallel, and the memory answers a fixed number of cycles later. The unit multiplies those values by the programmed beam coordinates and subtracts the result from d0. It forwards the stream with a fixed latency.

The beam coordinates and a beam-valid flag are plain inputs, driven by configuration registers elsewhere. They are captured once per track, when the first word is accepted. Every output word carries that captured flag. Downstream logic can therefore tell corrected tracks from tracks that passed untouched. The unit accepts tracks back to back with no idle cycles, and it also accepts idle gaps inside a track.

Top module: `beam_spot_corrector`

## Requirements
- R1: A track is seven words counted on `in_valid` beats, starting from index 0. Word 0 holds the azimuth index in bits [9:0] and the segment in bits [12:10]. Bits [15:13] of word 0 are not used for the lookup. Exactly one lookup pair is issued per track, with `fl_rd_en` high for the single cycle after word 0 is accepted.
- R2: Both lane addresses are {bank[4:0], 3'b000, segment[2:0], azimuth[9:0]}. The sine lane uses bank `SIN_BANK` (default 0) and the cosine lane uses bank `COS_BANK` (default 1). Both lanes carry the same low 16 bits.
- R3: Table data are sampled exactly `FL_LAT` cycles (default 2) after `fl_rd_en` is high. The data are read as signed fixed point with `FRAC` (default 14) fraction bits.
- R4: When the captured beam flag is set, bits [11:0] of word 1 (signed d0) are replaced by d0 − floor((x·sin − y·cos) / 2^FRAC). Here x and y are the signed 16-bit beam coordinates. Bits [15:12] of word 1 pass through unchanged.
- R5: A corrected d0 outside [−2048, 2047] saturates to the nearest limit.
- R6: When the captured beam flag is clear, all seven words of the track, word 1 included, leave unchanged.
- R7: The beam coordinates and the flag are captured in the cycle word 0 is accepted. Changes to them later in the same track have no effect on that track.
- R8: Every accepted word appears at the output exactly `FL_LAT`+2 cycles after the cycle it was accepted in, and idle gaps are preserved. Words other than word 1 are never modified.
- R9: While and after an asynchronous reset, `out_valid` and `fl_rd_en` are low, and the word counter restarts at word 0.
- R10: `out_beam_ok` on every output word equals the flag captured for that word's track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Input track word |
| beam_x | input | 16 | Signed beam x coordinate, in d0 units |
| beam_y | input | 16 | Signed beam y coordinate, in d0 units |
| beam_valid | input | 1 | Beam fit usable |
| fl_rd_en | output | 1 | Lookup request, both lanes |
| fl_sin_addr | output | 21 | Sine lane table address |
| fl_cos_addr | output | 21 | Cosine lane table address |
| fl_sin_data | input | 16 | Sine lane data, `FL_LAT` cycles after the request |
| fl_cos_data | input | 16 | Cosine lane data, `FL_LAT` cycles after the request |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output track word |
| out_beam_ok | output | 1 | Track was corrected with a valid beam |

## Verification
The hardest case to reach from the ports is a change of the beam registers in the middle of a track. The stimulus holds one set of coordinates and the flag while word 0 is accepted, then drives different coordinates and a cleared flag from word 1 onward. The expected d0 still comes from the first set. A second hard case is a track whose words arrive with idle gaps, so that the d0 word reaches the output stage long after its lookup returned. Back-to-back tracks also let the next lookup overwrite the correction while the previous track is still draining. A reset asserted after three words of a track checks that the next track is again decoded from word 0.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int WORD_W    = 16;
    localparam int PHI_W     = 10;
    localparam int Z_W       = 3;
    localparam int D0_W      = 12;
    localparam int FA_W      = 21;
    localparam int BANK_W    = 5;
    localparam int IDX_W     = FA_W - BANK_W;
    localparam int TRK_WORDS = 7;
    localparam int BEAM_W    = 16;
    localparam int TAB_W     = 16;
    localparam int PROD_W    = BEAM_W + TAB_W;
    localparam int CNT_W     = $clog2(TRK_WORDS);

    // one word travelling through the alignment line
    typedef struct packed {
        logic              vld;
        logic              is_d0;
        logic              ok;
        logic [WORD_W-1:0] data;
    } beat_t;

    // clamp a wide signed result into the d0 field
    function automatic logic [D0_W-1:0] sat_d0(input logic signed [PROD_W+1:0] v);
        longint hi;
        longint lo;
        longint w;
        hi = longint'((64'sd1 <<< (D0_W - 1)) - 1);
        lo = -longint'(64'sd1 <<< (D0_W - 1));
        w  = longint'(v);
        if (w > hi)      return D0_W'(hi);
        else if (w < lo) return D0_W'(lo);
        else             return v[D0_W-1:0];
    endfunction

endpackage

// File: rtl/bsc_front.sv
module bsc_front
    import bsc_pkg::*;
#(
    parameter int SIN_BANK = 0,
    parameter int COS_BANK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [BEAM_W-1:0] beam_x,
    input  logic [BEAM_W-1:0] beam_y,
    input  logic              beam_valid,
    output logic              fl_rd_en,
    output logic [FA_W-1:0]   fl_sin_addr,
    output logic [FA_W-1:0]   fl_cos_addr,
    output logic [BEAM_W-1:0] bx,
    output logic [BEAM_W-1:0] by,
    output beat_t             beat
);

    localparam int                PAD_W   = IDX_W - Z_W - PHI_W;
    localparam logic [CNT_W-1:0]  LAST    = CNT_W'(TRK_WORDS - 1);
    localparam logic [CNT_W-1:0]  D0_IDX  = CNT_W'(1);
    localparam logic [BANK_W-1:0] SIN_SEL = BANK_W'(SIN_BANK);
    localparam logic [BANK_W-1:0] COS_SEL = BANK_W'(COS_BANK);

    typedef struct packed {
        logic [CNT_W-1:0]  idx;
        logic              req;
        logic [Z_W-1:0]    z;
        logic [PHI_W-1:0]  phi;
        logic [BEAM_W-1:0] bx;
        logic [BEAM_W-1:0] by;
        logic              bv;
    } front_t;

    front_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        if (in_valid) begin
            s_d.idx = (s_q.idx == LAST) ? '0 : s_q.idx + CNT_W'(1);
            if (s_q.idx == '0) begin
                s_d.req = 1'b1;
                s_d.phi = in_data[PHI_W-1:0];
                s_d.z   = in_data[PHI_W +: Z_W];
                s_d.bx  = beam_x;
                s_d.by  = beam_y;
                s_d.bv  = beam_valid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        beat.vld   = in_valid;
        beat.is_d0 = (s_q.idx == D0_IDX);
        beat.ok    = (s_q.idx == '0) ? beam_valid : s_q.bv;
        beat.data  = in_data;
    end

    assign fl_rd_en    = s_q.req;
    assign fl_sin_addr = {SIN_SEL, {PAD_W{1'b0}}, s_q.z, s_q.phi};
    assign fl_cos_addr = {COS_SEL, {PAD_W{1'b0}}, s_q.z, s_q.phi};
    assign bx          = s_q.bx;
    assign by          = s_q.by;

endmodule

// File: rtl/bsc_mac.sv
module bsc_mac
    import bsc_pkg::*;
#(
    parameter int FL_LAT = 2,
    parameter int FRAC   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_rd_en,
    input  logic [TAB_W-1:0]  fl_sin_data,
    input  logic [TAB_W-1:0]  fl_cos_data,
    input  logic [BEAM_W-1:0] bx,
    input  logic [BEAM_W-1:0] by,
    output logic [PROD_W:0]   corr
);

    typedef struct packed {
        logic [FL_LAT-1:0] pipe;
        logic [PROD_W:0]   corr;
    } mac_t;

    mac_t s_d, s_q;

    logic [FL_LAT:0]          tap;
    logic signed [PROD_W-1:0] px;
    logic signed [PROD_W-1:0] py;
    logic signed [PROD_W:0]   diff;

    always_comb begin
        tap    = {s_q.pipe, fl_rd_en};
        px     = $signed(bx) * $signed(fl_sin_data);
        py     = $signed(by) * $signed(fl_cos_data);
        diff   = {px[PROD_W-1], px} - {py[PROD_W-1], py};
        s_d    = s_q;
        s_d.pipe = tap[FL_LAT-1:0];
        if (tap[FL_LAT]) begin
            s_d.corr = diff >>> FRAC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign corr = s_q.corr;

endmodule

// File: rtl/bsc_delay.sv
module bsc_delay
    import bsc_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t in_beat,
    output beat_t out_beat
);

    beat_t [DEPTH-1:0] line_d, line_q;

    always_comb begin
        line_d[0] = in_beat;
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign out_beat = line_q[DEPTH-1];

endmodule

// File: rtl/beam_spot_corrector.sv
module beam_spot_corrector
    import bsc_pkg::*;
#(
    parameter int FL_LAT   = 2,
    parameter int SIN_BANK = 0,
    parameter int COS_BANK = 1,
    parameter int FRAC     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [BEAM_W-1:0] beam_x,
    input  logic [BEAM_W-1:0] beam_y,
    input  logic              beam_valid,
    output logic              fl_rd_en,
    output logic [FA_W-1:0]   fl_sin_addr,
    output logic [FA_W-1:0]   fl_cos_addr,
    input  logic [TAB_W-1:0]  fl_sin_data,
    input  logic [TAB_W-1:0]  fl_cos_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_beam_ok
);

    // alignment stages ahead of the output register
    localparam int DLY_DEPTH = FL_LAT + 1;

    typedef struct packed {
        logic              vld;
        logic              ok;
        logic [WORD_W-1:0] data;
    } out_t;

    logic [BEAM_W-1:0] bx, by;
    logic [PROD_W:0]   corr;
    beat_t             head, tail;
    out_t              o_d, o_q;

    logic signed [PROD_W+1:0] d0_ext;
    logic signed [PROD_W+1:0] corr_ext;
    logic signed [PROD_W+1:0] d0_new;

    bsc_front #(
        .SIN_BANK (SIN_BANK),
        .COS_BANK (COS_BANK)
    ) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .beam_x      (beam_x),
        .beam_y      (beam_y),
        .beam_valid  (beam_valid),
        .fl_rd_en    (fl_rd_en),
        .fl_sin_addr (fl_sin_addr),
        .fl_cos_addr (fl_cos_addr),
        .bx          (bx),
        .by          (by),
        .beat        (head)
    );

    bsc_mac #(
        .FL_LAT (FL_LAT),
        .FRAC   (FRAC)
    ) u_mac (
        .clk         (clk),
        .rst_n       (rst_n),
        .fl_rd_en    (fl_rd_en),
        .fl_sin_data (fl_sin_data),
        .fl_cos_data (fl_cos_data),
        .bx          (bx),
        .by          (by),
        .corr        (corr)
    );

    bsc_delay #(
        .DEPTH (DLY_DEPTH)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_beat  (head),
        .out_beat (tail)
    );

    always_comb begin
        d0_ext   = {{(PROD_W + 2 - D0_W){tail.data[D0_W-1]}}, tail.data[D0_W-1:0]};
        corr_ext = {corr[PROD_W], corr};
        d0_new   = d0_ext - corr_ext;
        o_d.vld  = tail.vld;
        o_d.ok   = tail.ok;
        o_d.data = tail.data;
        if (tail.vld && tail.is_d0 && tail.ok) begin
            o_d.data = {tail.data[WORD_W-1:D0_W], sat_d0(d0_new)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid   = o_q.vld;
    assign out_data    = o_q.data;
    assign out_beam_ok = o_q.ok;

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
    import bsc_pkg::*;
#(
    parameter int SIN_BANK = 0,
    parameter int COS_BANK = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            fl_rd_en,
    input logic [FA_W-1:0] fl_sin_addr,
    input logic [FA_W-1:0] fl_cos_addr,
    input logic            out_valid
);

    AST_BANK_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> (fl_sin_addr[FA_W-1 -: BANK_W] == BANK_W'(SIN_BANK)) &&
                     (fl_cos_addr[FA_W-1 -: BANK_W] == BANK_W'(COS_BANK))); // R2

    AST_SAME_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> (fl_sin_addr[IDX_W-1:0] == fl_cos_addr[IDX_W-1:0])); // R2

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> (fl_sin_addr[IDX_W-1:Z_W+PHI_W] == '0)); // R2

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |=> !fl_rd_en); // R1

    AST_REQ_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> $past(in_valid)); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !fl_rd_en)); // R9

endmodule

bind beam_spot_corrector bsc_checker #(
    .SIN_BANK (SIN_BANK),
    .COS_BANK (COS_BANK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .fl_rd_en    (fl_rd_en),
    .fl_sin_addr (fl_sin_addr),
    .fl_cos_addr (fl_cos_addr),
    .out_valid   (out_valid)
);

// File: tb/beam_spot_corrector_tb.sv
`timescale 1ns/1ps
module beam_spot_corrector_tb;

    localparam int LAT  = 2;
    localparam int PIPE = LAT + 2;
    localparam int MAXN = 64;

    typedef struct packed {
        logic [9:0]  phi;
        logic [2:0]  z;
        logic [11:0] d0;
        logic [15:0] xb;
        logic [15:0] yb;
        logic        bv;
    } vec_t;

    // stimulus; the expected d0 follows from the R4/R5 formula in ref_d0
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{10'd0,    3'd0, 12'd100,  16'h0000, 16'h0000, 1'b1},
        '{10'd17,   3'd2, 12'hFFB,  16'h012C, 16'hFF38, 1'b1},
        '{10'd1023, 3'd7, 12'd2047, 16'h7FFF, 16'h8000, 1'b1},
        '{10'd1023, 3'd7, 12'h800,  16'h7FFF, 16'h8000, 1'b1},
        '{10'd512,  3'd3, 12'd0,    16'h8000, 16'h7FFF, 1'b1},
        '{10'd300,  3'd5, 12'd1234, 16'h03E8, 16'h03E8, 1'b0},
        '{10'd77,   3'd1, 12'hC18,  16'hFF6A, 16'h0028, 1'b1},
        '{10'd900,  3'd4, 12'd2000, 16'h1388, 16'hE4A8, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [15:0] beam_x = '0;
    logic [15:0] beam_y = '0;
    logic        beam_valid = 1'b0;
    logic        fl_rd_en;
    logic [20:0] fl_sin_addr, fl_cos_addr;
    logic [15:0] fl_sin_data, fl_cos_data;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_beam_ok;

    always #2 clk = ~clk;

    beam_spot_corrector #(.FL_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .beam_x(beam_x), .beam_y(beam_y), .beam_valid(beam_valid),
        .fl_rd_en(fl_rd_en), .fl_sin_addr(fl_sin_addr), .fl_cos_addr(fl_cos_addr),
        .fl_sin_data(fl_sin_data), .fl_cos_data(fl_cos_data),
        .out_valid(out_valid), .out_data(out_data), .out_beam_ok(out_beam_ok)
    );

    function automatic logic [15:0] tab_val(input logic [20:0] a);
        return (a[15:0] * 16'd37) ^ {a[20:16], 11'd0};
    endfunction

    // table memory model: answer LAT cycles after the request
    logic [15:0] sin_p [LAT];
    logic [15:0] cos_p [LAT];
    always @(posedge clk) begin
        sin_p[0] <= fl_rd_en ? tab_val(fl_sin_addr) : 16'h0;
        cos_p[0] <= fl_rd_en ? tab_val(fl_cos_addr) : 16'h0;
        for (int i = 1; i < LAT; i++) begin
            sin_p[i] <= sin_p[i-1];
            cos_p[i] <= cos_p[i-1];
        end
    end
    assign fl_sin_data = sin_p[LAT-1];
    assign fl_cos_data = cos_p[LAT-1];

    function automatic logic [11:0] ref_d0(input logic [11:0] d0, input logic [9:0] phi,
                                           input logic [2:0] z, input logic [15:0] xb,
                                           input logic [15:0] yb);
        longint s = longint'($signed(tab_val({5'd0, 3'd0, z, phi})));
        longint c = longint'($signed(tab_val({5'd1, 3'd0, z, phi})));
        longint corr = (longint'($signed(xb)) * s - longint'($signed(yb)) * c) >>> 14;
        longint r = longint'($signed(d0)) - corr;
        if (r > 2047)  r = 2047;
        if (r < -2048) r = -2048;
        return r[11:0];
    endfunction

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_data [MAXN];
    logic        exp_ok   [MAXN];
    int          exp_cyc  [MAXN];
    string       exp_tag  [MAXN];
    int          exp_n = 0;
    logic [15:0] obs_data [MAXN];
    logic        obs_ok   [MAXN];
    int          obs_cyc  [MAXN];
    int          obs_n = 0;
    logic [20:0] exp_sa [MAXN];
    logic [20:0] exp_ca [MAXN];
    int          exp_rn = 0;
    logic [20:0] obs_sa [MAXN];
    logic [20:0] obs_ca [MAXN];
    int          obs_rn = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && obs_n < MAXN) begin
            obs_data[obs_n] = out_data;
            obs_ok[obs_n]   = out_beam_ok;
            obs_cyc[obs_n]  = cyc;
            obs_n++;
        end
        if (rst_n && fl_rd_en && obs_rn < MAXN) begin
            obs_sa[obs_rn] = fl_sin_addr;
            obs_ca[obs_rn] = fl_cos_addr;
            obs_rn++;
        end
    end

    task automatic check(input bit good, input string req, input longint act, input longint exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        exp_n = 0; obs_n = 0; exp_rn = 0; obs_rn = 0;
    endtask

    task automatic push_exp(input logic [15:0] d, input logic ok, input string tag);
        exp_data[exp_n] = d;
        exp_ok[exp_n]   = ok;
        exp_cyc[exp_n]  = cyc + PIPE;
        exp_tag[exp_n]  = tag;
        exp_n++;
    endtask

    // drive one word at the negedge; it is accepted at the next posedge
    task automatic drive_word(input logic [15:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
    endtask

    task automatic send_track(input vec_t v, input bit gap, input bit chg, input logic [7:0] id);
        logic [15:0] w;
        for (int k = 0; k < 7; k++) begin
            if (k == 0) w = {3'b101, v.z, v.phi};
            else if (k == 1) w = {4'h9, v.d0};
            else w = {4'(k), id, 4'hA};
            drive_word(w);
            if (k == 0) begin
                beam_x = v.xb; beam_y = v.yb; beam_valid = v.bv;
                exp_sa[exp_rn] = {5'd0, 3'd0, v.z, v.phi};
                exp_ca[exp_rn] = {5'd1, 3'd0, v.z, v.phi};
                exp_rn++;
            end
            if (k == 1 && chg) begin
                beam_x = 16'h7FFF; beam_y = 16'h0000; beam_valid = ~v.bv;
            end
            if (k == 1 && v.bv)
                push_exp({4'h9, ref_d0(v.d0, v.phi, v.z, v.xb, v.yb)}, v.bv,
                         chg ? "R7 d0 uses captured beam" : "R3 R4 R5 corrected d0");
            else if (k == 1)
                push_exp(w, v.bv, "R6 bypass d0");
            else
                push_exp(w, v.bv, v.bv ? "R8 word untouched" : "R6 bypass word");
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 16'hDEAD;
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic compare_logs();
        idle(PIPE + 3);
        check(obs_n == exp_n, "R8 word count", obs_n, exp_n);
        for (int i = 0; i < exp_n && i < obs_n; i++) begin
            check(obs_data[i] == exp_data[i], exp_tag[i], obs_data[i], exp_data[i]);
            check(obs_ok[i] == exp_ok[i], "R10 beam flag", obs_ok[i], exp_ok[i]);
            check(obs_cyc[i] == exp_cyc[i], "R8 latency", obs_cyc[i], exp_cyc[i]);
        end
        check(obs_rn == exp_rn, "R1 one lookup per track", obs_rn, exp_rn);
        for (int i = 0; i < exp_rn && i < obs_rn; i++) begin
            check(obs_sa[i] == exp_sa[i], "R2 sine address", obs_sa[i], exp_sa[i]);
            check(obs_ca[i] == exp_ca[i], "R2 cosine address", obs_ca[i], exp_ca[i]);
        end
        clear_logs();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t t;
        // R9 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
        check(fl_rd_en == 1'b0, "R9 fl_rd_en in reset", fl_rd_en, 0);
        rst_n = 1'b1;
        clear_logs();

        // table walk, tracks back to back
        for (int i = 0; i < NVEC; i++) begin
            send_track(VECS[i], 1'b0, 1'b0, 8'(i));
        end
        compare_logs();

        // R7 beam registers change after word 0
        t = '{10'd200, 3'd6, 12'd50, 16'd2000, 16'hF448, 1'b1};
        send_track(t, 1'b0, 1'b1, 8'h40);
        compare_logs();

        // R8 idle gaps inside a track
        t = '{10'd5, 3'd1, 12'hED4, 16'd800, 16'd900, 1'b1};
        send_track(t, 1'b1, 1'b0, 8'h50);
        compare_logs();

        // R9 reset in the middle of a track restarts the word counter
        drive_word({3'b0, 3'd3, 10'd44});
        drive_word(16'h9123);
        drive_word(16'h2222);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after mid-track reset", out_valid, 0);
        check(fl_rd_en == 1'b0, "R9 no lookup during reset", fl_rd_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_logs();
        t = '{10'd600, 3'd2, 12'd700, 16'hFB2E, 16'h10E1, 1'b1};
        send_track(t, 1'b0, 1'b0, 8'h60);
        compare_logs();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule